// File: doc/BRIEF.md
# Accumulator ALU with Zero and Carry Flags

This block is the arithmetic and logic unit of a small accumulator processor. Each operation takes two operand bytes, one from the accumulator A and one from register B, plus the stored carry flag. A 4-bit operation code chooses among add, add with carry, subtract, increment, decrement, compare, AND, OR and XOR. Increment and decrement use A only.

Work happens in two control steps. An execute strobe captures the result byte and the zero and carry flags into registers. A later store strobe raises a write enable towards A, carrying the captured result. A compare changes only the flags. It leaves the result register alone, and the store step after it writes nothing.

The result register reaches the shared data bus only while an output enable is high. A small condition decoder turns the flags into a branch-taken signal for the four jump tests. Equal and not-equal after a compare are the same as the zero and not-zero tests.

Top module: `acc_alu`

## Requirements
- R1: After reset the result register, zero flag, carry flag and pending-write state are all 0, so `bus_o`, `a_we_o`, `a_wdata_o`, `zero_o` and `carry_o` read 0.
- R2: On an execute strobe, opcode 0 (add) captures (A+B) mod 256 with carry set to the carry-out. Opcode 1 (add with carry) captures (A+B+carry) mod 256, using the flag value held before the strobe, with carry set to the carry-out.
- R3: Opcode 2 (subtract) captures (A-B) mod 256 with carry set when A < B unsigned. Opcode 3 (increment) captures (A+1) mod 256 with carry set when A = 255. Opcode 4 (decrement) captures (A-1) mod 256 with carry set when A = 0.
- R4: Opcodes 6 (AND), 7 (OR) and 8 (XOR) capture the bitwise result and clear carry.
- R5: On every valid execute, zero is set exactly when the 8-bit result is 0. For a compare (opcode 5), that result is A-B.
- R6: A compare updates the flags as a subtract would (carry set when A < B). It leaves the result register unchanged, and a following store does not assert `a_we_o`.
- R7: Result and flags change only on an execute strobe with opcode 0 to 8. Opcodes 9 to 15, or no strobe, leave them unchanged.
- R8: `a_we_o` is high in a cycle exactly when `store_i` is high and a non-compare execute has occurred since the last store. `a_wdata_o` always shows the result register. A store clears the pending write.
- R9: When execute and store fall in the same cycle, the store writes the result held before that cycle. The new execute then sets the pending state afresh: pending after a non-compare, not pending after a compare.
- R10: `bus_o` equals the result register while `oe_i` is 1 and is 0 otherwise.
- R11: `take_o` reports the condition selected by `cond_i`: 0 = zero set, 1 = zero clear, 2 = carry set, 3 = carry clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| exec_i | input | 1 | Execute strobe: capture result and flags |
| store_i | input | 1 | Write-back strobe towards A |
| oe_i | input | 1 | Drive the result onto the bus |
| cond_i | input | 2 | Jump condition select |
| bus_o | output | 8 | Result byte on the bus, 0 when not enabled |
| a_we_o | output | 1 | Write enable for accumulator A |
| a_wdata_o | output | 8 | Data for accumulator A |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / borrow flag |
| take_o | output | 1 | Selected jump condition holds |

## Verification
The execute and store strobes can land in the same cycle. The store must then write the previous result, while the pending state follows the new execute. The bench provokes this directly: it runs an add, then an execute together with a store. This is done once with a second add and once with a compare. A random phase later raises both strobes independently, many times over. In every cycle the reference model predicts `a_we_o` and `a_wdata_o` from the state it held before the edge, and predicts the next pending state with the execute taking precedence over the store.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W   = 4;
    localparam int COND_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_INC = 4'd3,
        OP_DEC = 4'd4,
        OP_CMP = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8
    } alu_op_e;

    typedef enum logic [COND_W-1:0] {
        CC_ZERO  = 2'd0,
        CC_NZERO = 2'd1,
        CC_CARRY = 2'd2,
        CC_NCARRY = 2'd3
    } cond_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NONE = 2'd3
    } logic_op_e;

    typedef struct packed {
        logic      valid;
        logic      use_arith;
        logic      zero_b;
        logic      inv_b;
        logic      cin_one;
        logic      cin_flag;
        logic      borrow;
        logic      is_cmp;
        logic_op_e lop;
    } dec_t;

endpackage

// File: rtl/acc_alu_dec.sv
module acc_alu_dec
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output dec_t            dec_o
);
    always_comb begin
        dec_o = '{valid: 1'b0, use_arith: 1'b0, zero_b: 1'b0, inv_b: 1'b0,
                  cin_one: 1'b0, cin_flag: 1'b0, borrow: 1'b0, is_cmp: 1'b0,
                  lop: LG_NONE};
        case (op_i)
            OP_ADD: begin
                dec_o.valid     = 1'b1;
                dec_o.use_arith = 1'b1;
            end
            OP_ADC: begin
                dec_o.valid     = 1'b1;
                dec_o.use_arith = 1'b1;
                dec_o.cin_flag  = 1'b1;
            end
            OP_SUB: begin
                dec_o.valid     = 1'b1;
                dec_o.use_arith = 1'b1;
                dec_o.inv_b     = 1'b1;
                dec_o.cin_one   = 1'b1;
                dec_o.borrow    = 1'b1;
            end
            OP_INC: begin
                dec_o.valid     = 1'b1;
                dec_o.use_arith = 1'b1;
                dec_o.zero_b    = 1'b1;
                dec_o.cin_one   = 1'b1;
            end
            OP_DEC: begin
                dec_o.valid     = 1'b1;
                dec_o.use_arith = 1'b1;
                dec_o.zero_b    = 1'b1;
                dec_o.inv_b     = 1'b1;
                dec_o.borrow    = 1'b1;
            end
            OP_CMP: begin
                dec_o.valid     = 1'b1;
                dec_o.use_arith = 1'b1;
                dec_o.inv_b     = 1'b1;
                dec_o.cin_one   = 1'b1;
                dec_o.borrow    = 1'b1;
                dec_o.is_cmp    = 1'b1;
            end
            OP_AND: begin
                dec_o.valid = 1'b1;
                dec_o.lop   = LG_AND;
            end
            OP_OR: begin
                dec_o.valid = 1'b1;
                dec_o.lop   = LG_OR;
            end
            OP_XOR: begin
                dec_o.valid = 1'b1;
                dec_o.lop   = LG_XOR;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  dec_t         dec_i,
    input  logic         cflag_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    logic [W-1:0] bop;
    logic         cin;
    logic [W:0]   full;

    always_comb begin
        bop = dec_i.zero_b ? '0 : b_i;
        if (dec_i.inv_b) begin
            bop = ~bop;
        end
        cin     = dec_i.cin_one | (dec_i.cin_flag & cflag_i);
        full    = {1'b0, a_i} + {1'b0, bop} + {{W{1'b0}}, cin};
        sum_o   = full[W-1:0];
        carry_o = dec_i.borrow ? ~full[W] : full[W];
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_op_e    lop_i,
    output logic [W-1:0] y_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (lop_i)
                LG_AND:  y_o[i] = a_i[i] & b_i[i];
                LG_OR:   y_o[i] = a_i[i] | b_i[i];
                LG_XOR:  y_o[i] = a_i[i] ^ b_i[i];
                default: y_o[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
    import acc_alu_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  logic              zero_i,
    input  logic              carry_i,
    output logic              take_o
);
    always_comb begin
        case (cond_i)
            CC_ZERO:   take_o = zero_i;
            CC_NZERO:  take_o = ~zero_i;
            CC_CARRY:  take_o = carry_i;
            default:   take_o = ~carry_i;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic              exec_i,
    input  logic              store_i,
    input  logic              oe_i,
    input  logic [COND_W-1:0] cond_i,
    output logic [W-1:0]      bus_o,
    output logic              a_we_o,
    output logic [W-1:0]      a_wdata_o,
    output logic              zero_o,
    output logic              carry_o,
    output logic              take_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         zf;
        logic         cf;
        logic         pend;
    } state_t;

    state_t st_d, st_q;

    dec_t         dec;
    logic [W-1:0] arith_y;
    logic         arith_c;
    logic [W-1:0] logic_y;
    logic [W-1:0] op_y;
    logic         op_c;

    acc_alu_dec u_dec (
        .op_i  (op_i),
        .dec_o (dec)
    );

    acc_alu_arith #(.W(W)) u_arith (
        .a_i     (a_i),
        .b_i     (b_i),
        .dec_i   (dec),
        .cflag_i (st_q.cf),
        .sum_o   (arith_y),
        .carry_o (arith_c)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .lop_i (dec.lop),
        .y_o   (logic_y)
    );

    acc_alu_cond u_cond (
        .cond_i  (cond_i),
        .zero_i  (st_q.zf),
        .carry_i (st_q.cf),
        .take_o  (take_o)
    );

    always_comb begin
        op_y = dec.use_arith ? arith_y : logic_y;
        op_c = dec.use_arith ? arith_c : 1'b0;
        st_d = st_q;
        if (store_i) begin
            st_d.pend = 1'b0;
        end
        if (exec_i && dec.valid) begin
            st_d.zf   = (op_y == '0);
            st_d.cf   = op_c;
            st_d.pend = ~dec.is_cmp;
            if (!dec.is_cmp) begin
                st_d.res = op_y;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_o     = oe_i ? st_q.res : '0;
    assign a_we_o    = store_i & st_q.pend;
    assign a_wdata_o = st_q.res;
    assign zero_o    = st_q.zf;
    assign carry_o   = st_q.cf;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic [W-1:0]      a_i,
    input logic              exec_i,
    input logic              store_i,
    input logic              oe_i,
    input logic [W-1:0]      bus_o,
    input logic              a_we_o,
    input logic              zero_o,
    input logic              carry_o
);
    a_r8_we_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        a_we_o |-> store_i);

    a_r10_bus_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i |-> (bus_o == '0));

    a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_i || op_i > OP_XOR) |=> ($stable(zero_o) && $stable(carry_o)));

    a_r4_logic_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=> !carry_o);

    a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_CMP) |=> !a_we_o);

    a_r3_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_INC && a_i == {W{1'b1}}) |=> (carry_o && zero_o));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .a_i     (a_i),
    .exec_i  (exec_i),
    .store_i (store_i),
    .oe_i    (oe_i),
    .bus_o   (bus_o),
    .a_we_o  (a_we_o),
    .zero_o  (zero_o),
    .carry_o (carry_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] a_i = '0, b_i = '0;
    logic       exec_i = 1'b0, store_i = 1'b0, oe_i = 1'b0;
    logic [1:0] cond_i = '0;
    logic [7:0] bus_o, a_wdata_o;
    logic       a_we_o, zero_o, carry_o, take_o;

    int n_checks = 0;
    int n_fail = 0;

    int m_res = 0, m_z = 0, m_c = 0, m_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .exec_i(exec_i), .store_i(store_i), .oe_i(oe_i), .cond_i(cond_i),
        .bus_o(bus_o), .a_we_o(a_we_o), .a_wdata_o(a_wdata_o),
        .zero_o(zero_o), .carry_o(carry_o), .take_o(take_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // One cycle: drive at negedge, compare all outputs, then advance the model.
    task automatic step(input int op, input int a, input int b, input bit ex,
                        input bit st, input bit oe, input int cc, input string tag);
        int e_take;
        int s;
        int nres, nz, nc, npend;
        @(negedge clk);
        op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0];
        exec_i = ex; store_i = st; oe_i = oe; cond_i = cc[1:0];
        #1;
        case (cc)
            0: e_take = m_z;
            1: e_take = !m_z;
            2: e_take = m_c;
            default: e_take = !m_c;
        endcase
        check(tag, "bus", int'(bus_o), oe ? m_res : 0);
        check(tag, "a_we", int'(a_we_o), (st && m_pend) ? 1 : 0);
        check(tag, "a_wdata", int'(a_wdata_o), m_res);
        check(tag, "zero", int'(zero_o), m_z);
        check(tag, "carry", int'(carry_o), m_c);
        check(tag, "take", int'(take_o), e_take);
        nres = m_res; nz = m_z; nc = m_c; npend = m_pend;
        if (st) npend = 0;
        if (ex && op <= 8) begin
            s = 0;
            case (op)
                0: begin s = a + b; nc = s / 256; end
                1: begin s = a + b + m_c; nc = s / 256; end
                2, 5: begin s = a - b; nc = (a < b) ? 1 : 0; end
                3: begin s = a + 1; nc = (a == 255) ? 1 : 0; end
                4: begin s = a - 1; nc = (a == 0) ? 1 : 0; end
                6: begin s = a & b; nc = 0; end
                7: begin s = a | b; nc = 0; end
                default: begin s = a ^ b; nc = 0; end
            endcase
            s = s & 255;
            nz = (s == 0) ? 1 : 0;
            if (op != 5) nres = s;
            npend = (op != 5) ? 1 : 0;
        end
        @(posedge clk);
        m_res = nres; m_z = nz; m_c = nc; m_pend = npend;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "bus", int'(bus_o), 0);
        check("R1", "a_we", int'(a_we_o), 0);
        check("R1", "zero", int'(zero_o), 0);
        check("R1", "carry", int'(carry_o), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 1, 1, 0, "R1");

        // R2: add with carry-out, then add with carry-in
        step(0, 200, 100, 1, 0, 0, 2, "R2");
        step(1, 1, 2, 1, 0, 1, 2, "R2");
        step(0, 0, 0, 0, 1, 1, 2, "R2");
        step(1, 255, 0, 1, 0, 1, 2, "R2");
        // R3: subtract borrow, increment wrap, decrement at 0
        step(2, 5, 9, 1, 0, 1, 2, "R3");
        step(3, 255, 0, 1, 0, 1, 0, "R3");
        step(4, 0, 0, 1, 0, 1, 2, "R3");
        step(4, 1, 0, 1, 0, 1, 0, "R3");
        // R4: logic ops clear carry
        step(2, 0, 1, 1, 0, 1, 2, "R4");
        step(6, 8'hF0, 8'h3C, 1, 0, 1, 3, "R4");
        step(7, 8'h0F, 8'h30, 1, 0, 1, 2, "R4");
        step(8, 8'hAA, 8'hAA, 1, 0, 1, 0, "R4");
        // R5/R6: compare equal and less-than, result held, store blocked
        step(0, 7, 7, 1, 0, 1, 0, "R5");
        step(5, 7, 7, 1, 0, 1, 0, "R5");
        step(5, 3, 4, 1, 0, 1, 2, "R6");
        step(0, 0, 0, 0, 1, 1, 1, "R6");
        // R7: undefined opcodes and idle strobe
        step(0, 1, 1, 1, 0, 1, 0, "R7");
        for (int k = 9; k < 16; k++) step(k, 0, 0, 1, 0, 1, 1, "R7");
        step(0, 0, 0, 0, 0, 1, 1, "R7");
        // R8: write-back consumes pending
        step(0, 0, 0, 0, 1, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 1, 0, "R8");
        // R9: execute and store together
        step(0, 10, 20, 1, 0, 1, 0, "R9");
        step(0, 1, 1, 1, 1, 1, 0, "R9");
        step(0, 0, 0, 0, 1, 1, 0, "R9");
        step(0, 10, 20, 1, 0, 1, 0, "R9");
        step(5, 1, 1, 1, 1, 1, 0, "R9");
        step(0, 0, 0, 0, 1, 1, 0, "R9");
        // R10/R11: bus gating and all conditions
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, k % 2, k, "R11");
        step(0, 0, 0, 0, 0, 0, 0, "R10");
        // mixed random traffic
        for (int k = 0; k < 2000; k++) begin
            step(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 3)), "R9");
        end
        summary();
    end
endmodule